// File: doc/BRIEF.md
# Wait-State Memory Read Controller

This block is the processor-side master for single-word reads from a memory that is slower than the core clock. The core raises a request together with an address. The controller then runs a fixed sequence of bus cycles. First it presents the address with the strobe inactive. Next it pulls the active-low read strobe down. It then holds the strobe low for a configurable number of empty wait cycles so that the memory has time to answer. Finally it releases the strobe, latches the data bus on that same edge and returns the word with a one-cycle completion pulse.

The number of wait cycles is fixed for each read. The parameter `WAIT_FROM_PORT` selects the source of that number. When it is 1, the count comes from the `wait_count` input, sampled when the request is accepted. When it is 0, the count comes from the parameter `DEFAULT_WAITS`. Requests that arrive while a read is in progress are dropped. There is no handshake beyond the request and completion signals.

Top module: `rdws_read_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_rd_n` is 1, `rd_done` is 0, `busy` is 0, `mem_addr` is 0 and `rd_data` is 0.
- R2: A request seen at a clock edge while idle starts the address cycle in the next cycle. In that cycle `mem_addr` equals the request address, `mem_rd_n` is 1 and `busy` is 1.
- R3: In the cycle after the address cycle, `mem_rd_n` is 0 (the strobe cycle).
- R4: After the strobe cycle, `mem_rd_n` stays 0 for exactly N wait cycles. In port mode N is `wait_count` sampled at acceptance, and a value of 0 is treated as 1. Changes to `wait_count` during a read have no effect.
- R5: In the cycle after the last wait cycle, `rd_done` is 1 for exactly one cycle and `mem_rd_n` is 1. In that cycle `rd_data` equals the `mem_data` value present during the last wait cycle.
- R6: `mem_addr` holds the request address without change from the address cycle through the last wait cycle. Whenever `busy` is 0, `mem_addr` is 0.
- R7: A request raised while `busy` is 1 is ignored. The address, the wait count and the timing of the current read are unchanged, and no second read follows.
- R8: `busy` is 1 from the address cycle through the last wait cycle and is 0 in the cycle where `rd_done` is 1.
- R9: `rd_data` keeps the last captured word until the next read completes.
- R10: A request raised in the `rd_done` cycle is accepted, so its address cycle follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request from the core |
| req_addr | input | ADDR_W | Address of the requested word |
| wait_count | input | WAIT_W | Number of wait cycles (port mode only; 0 treated as 1) |
| rd_data | output | DATA_W | Last word captured from the memory |
| rd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a read sequence occupies the bus |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_data | input | DATA_W | Data bus from the memory |

## Verification
Take the clock edge that accepts a request as edge 0. The address cycle is the cycle after edge 0 and the strobe cycle follows it. The N wait cycles come next, and `rd_done` with the captured word appears N+3 cycles after edge 0. The bench drives inputs and samples outputs on falling edges, and it steps through every one of these cycles one at a time, checking the strobe, address and busy values in each.

The behavioural memory drives valid data only once the strobe has been low for N cycles and drives a marker value before that. A capture made one cycle early or late therefore produces a wrong word. Ignored requests are checked by observing the address, the strobe length and the absence of a second read after completion.

// File: rtl/rdws_pkg.sv
package rdws_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ADDR   = 2'd1,
      PH_STROBE = 2'd2,
      PH_WAIT   = 2'd3
   } rdws_phase_e;

endpackage

// File: rtl/rdws_wait_counter.sv
module rdws_wait_counter #(
   parameter int WAIT_W         = 4,
   parameter int DEFAULT_WAITS  = 1,
   parameter bit WAIT_FROM_PORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   input  logic [WAIT_W-1:0] wait_count,
   output logic              last
);

   localparam int MAX_WAITS = (1 << WAIT_W) - 1;

   logic [WAIT_W-1:0] n_sel;
   logic [WAIT_W-1:0] remain_q;

   if (WAIT_W < 1) begin : g_bad_width
      $error("rdws_wait_counter: WAIT_W must be at least 1");
   end
   if ((DEFAULT_WAITS < 1) || (DEFAULT_WAITS > MAX_WAITS)) begin : g_bad_default
      $error("rdws_wait_counter: DEFAULT_WAITS out of range");
   end

   if (WAIT_FROM_PORT) begin : g_port_count
      always_comb begin
         n_sel = (wait_count == '0) ? WAIT_W'(1) : wait_count;
      end
   end else begin : g_fixed_count
      logic unused_cfg;
      assign unused_cfg = ^wait_count;
      always_comb begin
         n_sel = WAIT_W'(DEFAULT_WAITS);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= n_sel - WAIT_W'(1);
      end else if (step && (remain_q != '0)) begin
         remain_q <= remain_q - WAIT_W'(1);
      end
   end

   assign last = (remain_q == '0);

   assert_wait_nonzero_R4 : assert property (@(posedge clk) disable iff (rst)
      load |-> (n_sel != '0));

endmodule

// File: rtl/rdws_sequencer.sv
module rdws_sequencer
   import rdws_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic wait_last,
   output logic accept,
   output logic capture,
   output logic count_step,
   output logic busy,
   output logic rd_n
);

   rdws_phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (req) phase_d = PH_ADDR;
         PH_ADDR:   phase_d = PH_STROBE;
         PH_STROBE: phase_d = PH_WAIT;
         PH_WAIT:   if (wait_last) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_IDLE;
      else     phase_q <= phase_d;
   end

   assign accept     = (phase_q == PH_IDLE) && req;
   assign count_step = (phase_q == PH_WAIT);
   assign capture    = (phase_q == PH_WAIT) && wait_last;
   assign busy       = (phase_q != PH_IDLE);
   assign rd_n       = !((phase_q == PH_STROBE) || (phase_q == PH_WAIT));

   assert_addr_cycle_strobe_high_R2 : assert property (@(posedge clk) disable iff (rst)
      accept |=> (busy && rd_n));

   assert_strobe_after_addr_R3 : assert property (@(posedge clk) disable iff (rst)
      (busy && rd_n) |=> (!rd_n && busy));

   assert_release_ends_busy_R8 : assert property (@(posedge clk) disable iff (rst)
      capture |=> (!busy && rd_n));

endmodule

// File: rtl/rdws_datapath.sv
module rdws_datapath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic              busy,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done
);

   logic [ADDR_W-1:0] addr_q;

   if ((ADDR_W < 1) || (DATA_W < 1)) begin : g_bad_width
      $error("rdws_datapath: bus widths must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         rd_data <= '0;
         rd_done <= 1'b0;
      end else begin
         if (accept)  addr_q  <= req_addr;
         if (capture) rd_data <= mem_data;
         rd_done <= capture;
      end
   end

   assign mem_addr = busy ? addr_q : '0;

   assert_done_single_R5 : assert property (@(posedge clk) disable iff (rst)
      rd_done |=> !rd_done);

   assert_addr_stable_R6 : assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(mem_addr));

   assert_idle_addr_zero_R6 : assert property (@(posedge clk) disable iff (rst)
      !busy |-> (mem_addr == '0));

   assert_data_held_R9 : assert property (@(posedge clk) disable iff (rst)
      !capture |=> $stable(rd_data));

endmodule

// File: rtl/rdws_read_ctrl.sv
module rdws_read_ctrl #(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 32,
   parameter int WAIT_W         = 4,
   parameter int DEFAULT_WAITS  = 1,
   parameter bit WAIT_FROM_PORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WAIT_W-1:0] wait_count,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_n,
   input  logic [DATA_W-1:0] mem_data
);

   logic accept;
   logic capture;
   logic count_step;
   logic wait_last;

   rdws_wait_counter #(
      .WAIT_W         (WAIT_W),
      .DEFAULT_WAITS  (DEFAULT_WAITS),
      .WAIT_FROM_PORT (WAIT_FROM_PORT)
   ) i_counter (
      .clk        (clk),
      .rst        (rst),
      .load       (accept),
      .step       (count_step),
      .wait_count (wait_count),
      .last       (wait_last)
   );

   rdws_sequencer i_seq (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .wait_last  (wait_last),
      .accept     (accept),
      .capture    (capture),
      .count_step (count_step),
      .busy       (busy),
      .rd_n       (mem_rd_n)
   );

   rdws_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_data (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .capture  (capture),
      .busy     (busy),
      .req_addr (req_addr),
      .mem_data (mem_data),
      .mem_addr (mem_addr),
      .rd_data  (rd_data),
      .rd_done  (rd_done)
   );

   assert_done_strobe_high_R5 : assert property (@(posedge clk) disable iff (rst)
      rd_done |-> (mem_rd_n && !busy));

   assert_done_follows_strobe_R5 : assert property (@(posedge clk) disable iff (rst)
      rd_done |-> !$past(mem_rd_n));

endmodule

// File: tb/test_rdws_read_ctrl.sv
module test_rdws_read_ctrl;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int WW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [WW-1:0] wait_count = '0;
   logic [DW-1:0] rd_data;
   logic          rd_done;
   logic          busy;
   logic [AW-1:0] mem_addr;
   logic          mem_rd_n;
   logic [DW-1:0] mem_data;

   int checks = 0;
   int failures = 0;
   int model_n = 1;
   int low_cnt = 0;

   always #10 clk = ~clk;

   rdws_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW),
                    .DEFAULT_WAITS(1), .WAIT_FROM_PORT(1'b1)) i_rdws_read_ctrl (
      .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
      .wait_count(wait_count), .rd_data(rd_data), .rd_done(rd_done),
      .busy(busy), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_data(mem_data));

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a ^ 16'hA5C3, a};
   endfunction

   // slow memory: valid word only after strobe has been low for model_n cycles
   always @(posedge clk) begin
      if (!mem_rd_n) low_cnt <= low_cnt + 1;
      else           low_cnt <= 0;
   end
   assign mem_data = (!mem_rd_n && (low_cnt >= model_n)) ? word_of(mem_addr)
                                                         : (32'hBAD0_0000 | DW'(low_cnt));

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(mem_rd_n == 1'b1, "R1 strobe in reset", DW'(mem_rd_n), 1);
      chk(!rd_done && !busy, "R1 done/busy in reset", DW'({rd_done, busy}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(mem_addr == '0, "R1 address after reset", DW'(mem_addr), 0);
      chk(rd_data == '0, "R1 data after reset", rd_data, 0);
      chk(mem_rd_n && !busy && !rd_done, "R1 idle after reset",
          DW'({mem_rd_n, busy, rd_done}), 32'h4);
   endtask

   // one read; poke raises a new request during the read (R7)
   task automatic t_read(input logic [AW-1:0] a, input logic [WW-1:0] cfg, input bit poke);
      int n;
      n = (cfg == 0) ? 1 : int'(cfg);
      model_n = n;
      req = 1'b1; req_addr = a; wait_count = cfg;
      @(negedge clk);
      req = 1'b0;
      chk(mem_addr == a, "R2 address cycle addr", DW'(mem_addr), DW'(a));
      chk(mem_rd_n && busy, "R2 address cycle strobe high busy", DW'({mem_rd_n, busy}), 3);
      if (poke) begin
         req = 1'b1; req_addr = ~a; wait_count = cfg + 4'd3;
      end
      @(negedge clk);
      chk(!mem_rd_n && busy, "R3 strobe cycle", DW'({mem_rd_n, busy}), 1);
      chk(mem_addr == a, "R6 addr in strobe cycle", DW'(mem_addr), DW'(a));
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!mem_rd_n, "R4 strobe low in wait", DW'(mem_rd_n), 0);
         chk(busy && !rd_done, "R8 busy in wait", DW'({busy, rd_done}), 2);
         chk(mem_addr == a, poke ? "R7 addr kept under new req" : "R6 addr stable",
             DW'(mem_addr), DW'(a));
      end
      @(negedge clk);
      req = 1'b0;
      chk(rd_done, "R5 done pulse", DW'(rd_done), 1);
      chk(mem_rd_n, "R4 strobe released after N waits", DW'(mem_rd_n), 1);
      chk(rd_data == word_of(a), "R5 captured word", rd_data, word_of(a));
      chk(!busy && mem_addr == '0, "R8 busy low and R6 idle addr zero",
          DW'({busy, mem_addr}), 0);
      @(negedge clk);
      chk(!rd_done, "R5 done lasts one cycle", DW'(rd_done), 0);
      chk(rd_data == word_of(a), "R9 data held", rd_data, word_of(a));
      if (poke) begin
         repeat (3) begin
            @(negedge clk);
            chk(!busy && mem_rd_n, "R7 no read from ignored req", DW'({busy, mem_rd_n}), 1);
         end
      end
   endtask

   task automatic t_basic();
      t_read(16'h1234, 4'd1, 1'b0);
   endtask

   task automatic t_waits();
      t_read(16'h0F0F, 4'd3, 1'b0);
      t_read(16'hFFFF, 4'd15, 1'b0);
      t_read(16'h0001, 4'd0, 1'b0);   // R4: zero treated as one
   endtask

   task automatic t_ignore();
      t_read(16'h4242, 4'd2, 1'b1);
   endtask

   task automatic t_chain();
      model_n = 2;
      req = 1'b1; req_addr = 16'hAAAA; wait_count = 4'd2;
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);            // strobe + 2 waits
      @(negedge clk);
      chk(rd_done && rd_data == word_of(16'hAAAA), "R10 first word",
          rd_data, word_of(16'hAAAA));
      req = 1'b1; req_addr = 16'h5555; wait_count = 4'd1;
      @(negedge clk);
      model_n = 1;
      req = 1'b0;
      chk(busy && mem_rd_n && mem_addr == 16'h5555, "R10 back-to-back address cycle",
          DW'(mem_addr), 32'h5555);
      @(negedge clk);                       // strobe
      chk(rd_data == word_of(16'hAAAA), "R9 data held during next read",
          rd_data, word_of(16'hAAAA));
      @(negedge clk);                       // wait
      @(negedge clk);
      chk(rd_done && rd_data == word_of(16'h5555), "R10 second word",
          rd_data, word_of(16'h5555));
      @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      t_reset();
      t_basic();
      t_waits();
      t_ignore();
      t_chain();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule